// File: doc/BRIEF.md
# Multiplexed Address/Data Burst-Read Controller

This block is the host side of a synchronous burst read from a flash device that shares one 16-bit bus between address and data. A request carries a word address and a burst-length code. The controller puts the address on the bus in two strobed phases, upper bits first and then lower bits. It holds the lower address for one more cycle, then asserts output enable and releases its drivers in that same cycle. It waits a programmable number of clocks and then captures one word per clock, pausing whenever the device signals WAIT.

The latency count and the two WAIT configuration bits (polarity and timing) are quasi-static inputs. They are latched when a request is accepted. A burst ends when its last word has been captured or when it is aborted. Each end is marked by a single done pulse. Chip enable then stays high for a recovery gap before the next request is accepted. Only one early abort (one before any data arrives) is allowed between completed bursts.

Top module: `mux_burst_reader`

## Requirements
- R1: An accepted request produces two bus cycles with address strobe low and chip enable low. The first drives the zero-extended address bits [ADDR_W-1:16] on `ad_o`. The second drives bits [15:0]. The strobe is high for exactly one cycle between them. `ad_oe_o` is high in both.
- R2: Output enable stays high in every cycle where the address strobe is low. In the cycle right after the lower address phase, `ad_o` still drives bits [15:0] with `ad_oe_o` high and output enable high.
- R3: `ad_oe_o` is low in every cycle where output enable is low. After output enable has been low, the drivers come back only after output enable has been high for at least one cycle.
- R4: Let the lower address phase be bus cycle 0, and let L be the latched latency, with values below 2 treated as 2. The first data word can be captured at the end of cycle L. Each captured word appears on `rd_data_o` with `rd_valid_o` high in the following cycle, in bus order.
- R5: When `cfg_wait_pol_i` is 1, WAIT is active when `bus_wait_i` is high. When it is 0, WAIT is active when `bus_wait_i` is low.
- R6: When `cfg_wait_early_i` is 0, an active WAIT blocks capture in the same cycle. When it is 1, an active WAIT blocks capture in the next cycle.
- R7: `req_len_i` sets the burst length: 0 gives 4 words, 1 gives 8, 2 gives 16 and 3 is continuous. After the last word, `done_o` pulses once, in the same cycle as that word's `rd_valid_o`, with chip enable high.
- R8: After `done_o`, chip enable stays high and `req_ready_o` stays low for two cycles. `req_ready_o` rises in the third cycle.
- R9: `req_abort_i` before the first captured word ends the burst with no data and a done pulse, but only when the abort allowance is armed. The allowance is armed after reset and is used up by such an abort. While it is used up, an early abort is ignored and the burst completes.
- R10: `req_abort_i` after at least one word has been captured always ends the burst. No word is captured on that edge. This counts as a completed burst and re-arms the allowance.
- R11: Latency and WAIT configuration changes made after acceptance have no effect on the running burst.
- R12: The write enable output is held high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request present |
| req_ready_o | output | 1 | Controller idle, request accepted this cycle |
| req_addr_i | input | ADDR_W | Word address |
| req_len_i | input | 2 | Burst length code |
| req_abort_i | input | 1 | Terminate the running burst |
| cfg_latency_i | input | LAT_W | Latency count in clocks |
| cfg_wait_pol_i | input | 1 | WAIT polarity, 1 = active high |
| cfg_wait_early_i | input | 1 | WAIT leads data by one cycle |
| flash_ce_n_o | output | 1 | Chip enable, active low |
| flash_adv_n_o | output | 1 | Address strobe, active low |
| flash_oe_n_o | output | 1 | Output enable, active low |
| flash_we_n_o | output | 1 | Write enable, active low |
| ad_o | output | 16 | Address value for the shared bus |
| ad_oe_o | output | 1 | Host driver enable for the shared bus |
| ad_i | input | 16 | Shared bus as seen by the host |
| bus_wait_i | input | 1 | Device WAIT |
| rd_data_o | output | 16 | Captured word |
| rd_valid_o | output | 1 | `rd_data_o` holds a new word |
| done_o | output | 1 | Burst finished |

## Verification
The bench sweeps latency 1 to 5, all fixed lengths, both WAIT polarities and both WAIT timings. It uses stall patterns that include a stall on the very first data cycle. A lookahead handled off by one cycle, or a polarity that is not inverted, would shift the first-word cycle or capture the filler value the model drives during stalls. Right after each request is accepted, the bench scrambles the configuration inputs, so a design that reads them live would run with the wrong latency. A sequence of aborts covers three cases: an early abort that is honoured, a second one that must be ignored, and one after data that always stops the burst. A guard that never re-arms, or that never disarms, gives the wrong word count.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_AHI, ST_GAP, ST_ALO, ST_HOLD, ST_LAT, ST_DATA, ST_RECOV
  } mbr_state_e;

  localparam logic [1:0] LEN_CONT = 2'd3;

  function automatic logic [7:0] len_words(input logic [1:0] code);
    return 8'd4 << code;
  endfunction
endpackage

// File: rtl/mbr_wait_gate.sv
module mbr_wait_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wait_i,
  input  logic pol_i,
  input  logic early_i,
  output logic stall_o
);
  logic act_now, act_q;

  assign act_now = pol_i ? wait_i : ~wait_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act_now;

  // early mode: the level seen last cycle governs this cycle's word
  assign stall_o = early_i ? act_q : act_now;
endmodule

// File: rtl/mbr_beat_counter.sv
module mbr_beat_counter #(
  parameter int BEAT_W = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [1:0] len_i,
  input  logic       beat_i,
  output logic       last_o,
  output logic       any_o
);
  import mbr_pkg::*;

  logic [BEAT_W-1:0] rem_q;
  logic              cont_q, any_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      cont_q <= 1'b0;
      any_q  <= 1'b0;
    end else if (load_i) begin
      rem_q  <= BEAT_W'(len_words(len_i));
      cont_q <= (len_i == LEN_CONT);
      any_q  <= 1'b0;
    end else if (beat_i) begin
      rem_q  <= rem_q - 1'b1;
      any_q  <= 1'b1;
    end
  end

  assign last_o = !cont_q && (rem_q == BEAT_W'(1));
  assign any_o  = any_q;
endmodule

// File: rtl/mbr_abort_guard.sv
module mbr_abort_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic consume_i,
  input  logic rearm_i,
  output logic armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        armed_o <= 1'b1;
    else if (rearm_i)   armed_o <= 1'b1;
    else if (consume_i) armed_o <= 1'b0;
endmodule

// File: rtl/mux_burst_reader.sv
module mux_burst_reader #(
  parameter int ADDR_W = 24,
  parameter int LAT_W  = 4,
  parameter int BEAT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_len_i,
  input  logic              req_abort_i,
  input  logic [LAT_W-1:0]  cfg_latency_i,
  input  logic              cfg_wait_pol_i,
  input  logic              cfg_wait_early_i,
  output logic              flash_ce_n_o,
  output logic              flash_adv_n_o,
  output logic              flash_oe_n_o,
  output logic              flash_we_n_o,
  output logic [15:0]       ad_o,
  output logic              ad_oe_o,
  input  logic [15:0]       ad_i,
  input  logic              bus_wait_i,
  output logic [15:0]       rd_data_o,
  output logic              rd_valid_o,
  output logic              done_o
);
  import mbr_pkg::*;

  localparam int HI_W = ADDR_W - 16;
  localparam logic [LAT_W-1:0] LAT_MIN = LAT_W'(2);
  localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

  mbr_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [LAT_W-1:0]  lat_q, cnt_q;
  logic              pol_q, early_q, rcnt_q;
  logic              stall, last, any, armed;
  logic              load, take, fin, consume, rearm;

  mbr_wait_gate u_wait (
    .clk_i, .rst_ni, .wait_i(bus_wait_i), .pol_i(pol_q), .early_i(early_q), .stall_o(stall)
  );

  mbr_beat_counter #(.BEAT_W(BEAT_W)) u_beats (
    .clk_i, .rst_ni, .load_i(load), .len_i(req_len_i), .beat_i(take),
    .last_o(last), .any_o(any)
  );

  mbr_abort_guard u_guard (
    .clk_i, .rst_ni, .consume_i(consume), .rearm_i(rearm), .armed_o(armed)
  );

  always_comb begin
    state_d = state_q;
    load = 1'b0; take = 1'b0; fin = 1'b0; consume = 1'b0; rearm = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) begin state_d = ST_AHI; load = 1'b1; end
      ST_AHI:   state_d = ST_GAP;
      ST_GAP:   state_d = ST_ALO;
      ST_ALO:   state_d = ST_HOLD;
      ST_HOLD, ST_LAT: begin
        if (req_abort_i && armed) begin
          state_d = ST_RECOV; fin = 1'b1; consume = 1'b1;
        end else if (cnt_q == LAT_ONE) state_d = ST_DATA;
        else                           state_d = ST_LAT;
      end
      ST_DATA: begin
        if (req_abort_i && (any || armed)) begin
          state_d = ST_RECOV; fin = 1'b1;
          rearm   = any;
          consume = !any;
        end else if (!stall) begin
          take = 1'b1;
          if (last) begin state_d = ST_RECOV; fin = 1'b1; rearm = 1'b1; end
        end
      end
      ST_RECOV: if (rcnt_q) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      lat_q      <= LAT_MIN;
      pol_q      <= 1'b0;
      early_q    <= 1'b0;
      cnt_q      <= '0;
      rcnt_q     <= 1'b0;
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      state_q    <= state_d;
      rd_valid_o <= take;
      done_o     <= fin;
      rcnt_q     <= (state_q == ST_RECOV);
      if (take) rd_data_o <= ad_i;
      if (load) begin
        addr_q  <= req_addr_i;
        lat_q   <= (cfg_latency_i < LAT_MIN) ? LAT_MIN : cfg_latency_i;
        pol_q   <= cfg_wait_pol_i;
        early_q <= cfg_wait_early_i;
      end
      if (state_q == ST_ALO) cnt_q <= lat_q - LAT_ONE;
      else if ((state_q == ST_HOLD || state_q == ST_LAT) && cnt_q != LAT_ONE)
        cnt_q <= cnt_q - LAT_ONE;
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign flash_ce_n_o  = (state_q == ST_IDLE) || (state_q == ST_RECOV);
  assign flash_adv_n_o = !((state_q == ST_AHI) || (state_q == ST_ALO));
  assign flash_oe_n_o  = !((state_q == ST_LAT) || (state_q == ST_DATA));
  assign flash_we_n_o  = 1'b1;
  assign ad_oe_o       = (state_q == ST_AHI) || (state_q == ST_GAP) ||
                         (state_q == ST_ALO) || (state_q == ST_HOLD);
  assign ad_o = (state_q == ST_AHI || state_q == ST_GAP) ?
                16'(addr_q[ADDR_W-1:16]) : addr_q[15:0];

  if (HI_W > 16) begin : g_bad_width
    initial $error("ADDR_W upper part exceeds bus width");
  end
endmodule

// File: rtl/mbr_checker.sv
module mbr_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ce_n,
  input logic adv_n,
  input logic oe_n,
  input logic drv,
  input logic done,
  input logic valid
);
  a_r1_adv_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_n && !ce_n) |=> adv_n);

  a_r2_oe_off_in_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_n |-> oe_n);

  a_r3_release_with_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n |-> !drv);

  a_r3_redrive_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv |-> $past(oe_n));

  a_r4_capture_under_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid |-> $past(!oe_n));

  a_r7_done_ce_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> ce_n);

  a_r8_recovery_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_n) |=> ce_n);
endmodule

bind mux_burst_reader mbr_checker chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_n(flash_ce_n_o), .adv_n(flash_adv_n_o),
  .oe_n(flash_oe_n_o), .drv(ad_oe_o), .done(done_o), .valid(rd_valid_o)
);

// File: tb/mux_burst_reader_tb_top.sv
module mux_burst_reader_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        req_valid, req_ready, req_abort;
  logic [23:0] req_addr;
  logic [1:0]  req_len;
  logic [3:0]  cfg_lat;
  logic        cfg_pol, cfg_early;
  logic        ce_n, adv_n, oe_n, we_n, ad_oe, rd_valid, done;
  logic [15:0] ad_o, ad_i, rd_data;
  logic        wait_in;

  mux_burst_reader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_abort_i(req_abort),
    .cfg_latency_i(cfg_lat), .cfg_wait_pol_i(cfg_pol), .cfg_wait_early_i(cfg_early),
    .flash_ce_n_o(ce_n), .flash_adv_n_o(adv_n), .flash_oe_n_o(oe_n), .flash_we_n_o(we_n),
    .ad_o(ad_o), .ad_oe_o(ad_oe), .ad_i(ad_i), .bus_wait_i(wait_in),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .done_o(done)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model and monitor state
  bit          active = 0, phase = 0, pol_m = 1, early_m = 0;
  bit          hi_ok, lo_ok, hold_ok, ready_prev = 0;
  int          rel = 0, lat_m = 2, seed = 0, nb = 0, cyc = 0;
  int          words = 0, first_rel = -1, done_cnt = 0, oe_viol = 0, we_viol = 0;
  int          done_at = 0, ready_at = 0, ab_rel = -1, ab_words = -1;
  logic [23:0] cur_addr = '0;

  function automatic bit stall_at(input int k);
    return ((k + seed) % 4) == 3;
  endfunction

  function automatic logic [15:0] word_of(input int b);
    return cur_addr[15:0] + 16'(b) * 16'h0101;
  endfunction

  always @(negedge clk) begin
    bit st;
    cyc++;
    req_abort = 1'b0;
    if (rst_n) begin
      if (!ce_n && !adv_n) begin
        if (!phase) begin
          phase = 1;
          hi_ok = ad_oe && (ad_o == 16'(cur_addr[23:16]));
        end else begin
          phase  = 0; active = 1; rel = 0; nb = 0;
          lo_ok  = ad_oe && (ad_o == cur_addr[15:0]);
        end
      end else if (active) rel++;
      if (active && rel == 1) hold_ok = ad_oe && oe_n && (ad_o == cur_addr[15:0]);
      if (ce_n) begin active = 0; phase = 0; end
      if (!oe_n && ad_oe) oe_viol++;
      if (!we_n) we_viol++;
      if (rd_valid) begin
        chk(rd_data == word_of(words), "R4", rd_data, word_of(words));
        if (words == 0) first_rel = rel;
        words++;
      end
      if (done) begin done_cnt++; done_at = cyc; end
      if (req_ready && !ready_prev) ready_at = cyc;
      ready_prev = req_ready;
      if (active && rel == ab_rel) begin req_abort = 1'b1; ab_rel = -1; end
      if (ab_words > 0 && words == ab_words) begin req_abort = 1'b1; ab_words = -1; end
    end
    if (active && rel >= lat_m) begin
      if (stall_at(rel - lat_m)) ad_i = 16'hdead;
      else begin ad_i = word_of(nb); nb++; end
    end else ad_i = 16'h5a5a;
    if (early_m) st = active && (rel + 1 >= lat_m) && stall_at(rel + 1 - lat_m);
    else         st = active && (rel >= lat_m) && stall_at(rel - lat_m);
    wait_in = pol_m ? st : !st;
  end

  task automatic run(input logic [23:0] a, input int len, input int lat, input bit pol,
                     input bit early, input int sd, input int arel, input int awords,
                     input int exp_words, input bit chk_lat);
    int f, guard;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    cur_addr = a; seed = sd; pol_m = pol; early_m = early;
    lat_m = (lat < 2) ? 2 : lat;
    words = 0; first_rel = -1; done_cnt = 0; oe_viol = 0;
    hi_ok = 0; lo_ok = 0; hold_ok = 0;
    ab_rel = arel; ab_words = awords;
    req_addr = a; req_len = 2'(len); cfg_lat = 4'(lat); cfg_pol = pol; cfg_early = early;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // scrambled configuration must not reach the running burst
    cfg_lat = 4'(lat + 7); cfg_pol = !pol; cfg_early = !early;
    guard = 0;
    while (done_cnt == 0 && guard < 400) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    chk(hi_ok, "R1", hi_ok, 1);
    chk(lo_ok, "R1", lo_ok, 1);
    if (exp_words > 0) chk(hold_ok, "R2", hold_ok, 1);
    chk(oe_viol == 0, "R3", oe_viol, 0);
    chk(words == exp_words, "R7 R9 R10", words, exp_words);
    chk(done_cnt == 1, "R7", done_cnt, 1);
    chk(ready_at - done_at == 2, "R8", ready_at - done_at, 2);
    if (chk_lat) begin
      f = 0;
      while (stall_at(f)) f++;
      chk(first_rel == lat_m + f + 1, "R5 R6 R11", first_rel, lat_m + f + 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_addr = '0; req_len = '0;
    cfg_lat = 4'd2; cfg_pol = 1; cfg_early = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ce_n && adv_n && oe_n && !ad_oe && !rd_valid && !done, "R8 reset",
        {ce_n, adv_n, oe_n, ad_oe, rd_valid, done}, 6'b111000);
    chk(req_ready, "R8 reset", req_ready, 1);
    chk(we_n, "R12", we_n, 1);

    for (int lat = 1; lat <= 5; lat++)
      for (int len = 0; len < 3; len++)
        for (int pol = 0; pol < 2; pol++)
          for (int early = 0; early < 2; early++)
            run(24'h100000 + 24'(lat * 24'h011357) + 24'(len * 24'h020202), len, lat,
                1'(pol), 1'(early), (lat + len + pol + early) % 4, -1, -1, 4 << len, 1);

    // R9: first early abort honoured, second ignored, then re-armed
    run(24'h4455aa, 2, 5, 1, 0, 0, 2, -1, 0, 0);
    run(24'h4466bb, 2, 5, 0, 1, 1, 2, -1, 16, 0);
    run(24'h4477cc, 1, 5, 1, 1, 2, 2, -1, 0, 0);
    // R10: abort after data always stops a continuous burst and re-arms
    run(24'h5500f0, 3, 3, 0, 0, 1, -1, 6, 6, 0);
    run(24'h5511e0, 0, 5, 1, 0, 0, 3, -1, 0, 0);
    run(24'h5522d0, 0, 2, 1, 0, 3, 2, -1, 4, 0);

    chk(we_viol == 0, "R12", we_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule